// File: doc/BRIEF.md
# Addressed Serial Register Write Receiver

This block listens on a two-wire link made of a serial clock and a serial data line, both asynchronous to the system clock. It brings both lines into the system clock domain and takes one data bit on every rising edge of the serial clock. It groups the bits into fixed frames. Each frame has a device address, then a register index, then a data value. No start marker is used: the block finds frame boundaries only by counting clock edges from reset.

When a frame is complete, the block compares its device address with a constant set at build time. On a match, it drives a one-cycle write strobe with the index and the value, so that the surrounding logic can update its register file. The default index space has 32 live registers: channel positions, offset low bytes, offset high bytes and gains, eight of each. Frames for another device, and frames with an index outside that space, produce no write. In both cases the receiver is ready for the next frame at once.

Top module: `serial_reg_rx`

## Requirements
- R1: While reset is asserted and right after it, wr_stb_o is 0, wr_idx_o and wr_data_o are 0, and the receiver expects the first bit of a device address.
- R2: A bit is taken only on a rising edge of the synchronized serial clock, with the value of the data line at that edge. Changes on the data line while the serial clock is high or low have no effect.
- R3: A frame has three fields in this fixed order: ADDR_W (8) device address bits, IDX_W (6) index bits, DATA_W (8) data bits. Within each field the first bit received is the least significant bit.
- R4: The index field is right-justified, so wr_idx_o carries the received value 0..63 unshifted.
- R5: The device address is compared only after the last data bit. A frame whose address differs from DEV_ADDR gives no strobe and leaves wr_idx_o and wr_data_o unchanged, and the next bit starts a new device address.
- R6: For a matching frame with an index below REG_COUNT, wr_stb_o is high for exactly one system clock cycle, with wr_idx_o equal to the index and wr_data_o equal to the data byte.
- R7: A matching frame whose index is REG_COUNT (32) or more is ignored: no strobe, and the outputs keep their values.
- R8: wr_idx_o and wr_data_o change only together with a strobe, and they hold their values between strobes.
- R9: An assertion of reset in the middle of a frame discards the partial frame. The next frame after reset is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous, stable around the clock rise |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_idx_o | output | IDX_W (6) | Register index of the write |
| wr_data_o | output | DATA_W (8) | Data byte of the write |

## Verification
The bench builds the block with DEV_ADDR = 8'hB4, a value that is not its own bit reverse. A receiver that assembles fields in the wrong bit order therefore fails the address match. REG_COUNT is left at 32 with a 6-bit index. This puts both index 31 and indices 32, 42 and 63 within reach, so the in-range write path and the ignore path are both exercised. With the two-stage synchronizer, the bench holds each serial level for several system cycles. It also toggles the data line while the serial clock is high, to show that only the rising edge samples.

// File: rtl/serial_reg_rx_pkg.sv
package serial_reg_rx_pkg;
   typedef enum logic [1:0] {
      PH_DEV = 2'd0,
      PH_SUB = 2'd1,
      PH_VAL = 2'd2
   } phase_e;
endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_a,
   input  logic sdat_a,
   output logic rise_o,
   output logic bit_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("srx_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] clk_chain;
   logic [STAGES-1:0] dat_chain;
   logic              clk_prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_chain[0] <= 1'b0;
               dat_chain[0] <= 1'b0;
            end else begin
               clk_chain[0] <= sclk_a;
               dat_chain[0] <= sdat_a;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_chain[s] <= 1'b0;
               dat_chain[s] <= 1'b0;
            end else begin
               clk_chain[s] <= clk_chain[s-1];
               dat_chain[s] <= dat_chain[s-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= clk_chain[STAGES-1];
   end

   assign rise_o = clk_chain[STAGES-1] & ~clk_prev;
   assign bit_o  = dat_chain[STAGES-1];

   // R2: two rises need a low sample in between
   p_rise_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o)
      else $error("p_rise_spaced_r2");
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         bit_i,
   output logic [W-1:0] nxt_o
);
   if (W < 1) begin : g_bad_w
      $error("srx_shifter: W must be positive");
   end

   logic [W-1:0] q;

   if (W == 1) begin : g_one
      assign nxt_o = bit_i;
   end else begin : g_many
      assign nxt_o = {bit_i, q[W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= nxt_o;
   end

   // R2: the register only moves when a bit is taken
   p_hold_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(q))
      else $error("p_hold_no_shift_r2");
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import serial_reg_rx_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          IDX_W     = 6,
   parameter int          DATA_W    = 8,
   parameter int          SHIFT_W   = 8,
   parameter int          REG_COUNT = 32,
   parameter logic [7:0]  DEV_ADDR  = 8'h20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise_i,
   input  logic [SHIFT_W-1:0] nxt_i,
   output logic               wr_stb_o,
   output logic [IDX_W-1:0]   wr_idx_o,
   output logic [DATA_W-1:0]  wr_data_o
);
   localparam int CNT_MAX = (ADDR_W > IDX_W) ? ((ADDR_W > DATA_W) ? ADDR_W : DATA_W)
                                             : ((IDX_W > DATA_W) ? IDX_W : DATA_W);
   localparam int CNT_W = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] LAST_DEV = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] LAST_SUB = CNT_W'(IDX_W - 1);
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(DATA_W - 1);
   localparam logic [IDX_W:0]   IDX_LIMIT = (IDX_W + 1)'(REG_COUNT);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ADDR);

   if (ADDR_W > SHIFT_W || IDX_W > SHIFT_W || DATA_W > SHIFT_W) begin : g_bad_shift
      $error("srx_framer: SHIFT_W narrower than a field");
   end
   if (REG_COUNT < 1 || REG_COUNT > (1 << IDX_W)) begin : g_bad_count
      $error("srx_framer: REG_COUNT outside the index space");
   end

   phase_e             phase;
   logic [CNT_W-1:0]   cnt;
   logic [ADDR_W-1:0]  dev_q;
   logic [IDX_W-1:0]   sub_q;
   logic [IDX_W-1:0]   sub_now;
   logic [ADDR_W-1:0]  dev_now;
   logic [DATA_W-1:0]  val_now;
   logic               idx_ok;
   logic               hit;

   // fields enter at the top, so the newest field sits in the upper bits
   assign dev_now = nxt_i[SHIFT_W-1 -: ADDR_W];
   assign sub_now = nxt_i[SHIFT_W-1 -: IDX_W];
   assign val_now = nxt_i[SHIFT_W-1 -: DATA_W];

   if (REG_COUNT == (1 << IDX_W)) begin : g_full_space
      assign idx_ok = 1'b1;
   end else begin : g_part_space
      assign idx_ok = ({1'b0, sub_q} < IDX_LIMIT);
   end

   assign hit = (dev_q == MY_ADDR) && idx_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_DEV;
         cnt       <= '0;
         dev_q     <= '0;
         sub_q     <= '0;
         wr_stb_o  <= 1'b0;
         wr_idx_o  <= '0;
         wr_data_o <= '0;
      end else begin
         wr_stb_o <= 1'b0;
         if (rise_i) begin
            unique case (phase)
               PH_DEV: begin
                  if (cnt == LAST_DEV) begin
                     dev_q <= dev_now;
                     cnt   <= '0;
                     phase <= PH_SUB;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_SUB: begin
                  if (cnt == LAST_SUB) begin
                     sub_q <= sub_now;
                     cnt   <= '0;
                     phase <= PH_VAL;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_VAL: begin
                  if (cnt == LAST_VAL) begin
                     cnt   <= '0;
                     phase <= PH_DEV;
                     if (hit) begin
                        wr_stb_o  <= 1'b1;
                        wr_idx_o  <= sub_q;
                        wr_data_o <= val_now;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  cnt   <= '0;
                  phase <= PH_DEV;
               end
            endcase
         end
      end
   end

   // R6: strobe lasts one cycle
   p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o)
      else $error("p_stb_single_r6");
   // R2: a write only follows a sampled edge
   p_stb_after_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> $past(rise_i))
      else $error("p_stb_after_edge_r2");
   // R7: no strobe for an index beyond the live registers
   p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> ({1'b0, wr_idx_o} < IDX_LIMIT))
      else $error("p_idx_in_range_r7");
   // R8: outputs hold between strobes
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_o |-> ($stable(wr_idx_o) && $stable(wr_data_o)))
      else $error("p_out_hold_r8");
   // R3: bit counter stays inside the widest field
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(CNT_MAX))
      else $error("p_cnt_bound_r3");
   // R5: the framer always returns to the address phase after the data field
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && phase == PH_VAL && cnt == LAST_VAL) |=> (phase == PH_DEV && cnt == '0))
      else $error("p_wrap_r5");
endmodule

// File: rtl/serial_reg_rx.sv
module serial_reg_rx #(
   parameter int         ADDR_W      = 8,
   parameter int         IDX_W       = 6,
   parameter int         DATA_W      = 8,
   parameter int         REG_COUNT   = 32,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] DEV_ADDR    = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   output logic              wr_stb_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [DATA_W-1:0] wr_data_o
);
   localparam int SHIFT_W = (ADDR_W > IDX_W) ? ((ADDR_W > DATA_W) ? ADDR_W : DATA_W)
                                             : ((IDX_W > DATA_W) ? IDX_W : DATA_W);

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("serial_reg_rx: ADDR_W must be 1..8");
   end

   logic               rise;
   logic               sbit;
   logic [SHIFT_W-1:0] nxt;

   srx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_a (ser_clk_i),
      .sdat_a (ser_dat_i),
      .rise_o (rise),
      .bit_o  (sbit)
   );

   srx_shifter #(.W(SHIFT_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (rise),
      .bit_i    (sbit),
      .nxt_o    (nxt)
   );

   srx_framer #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .DATA_W    (DATA_W),
      .SHIFT_W   (SHIFT_W),
      .REG_COUNT (REG_COUNT),
      .DEV_ADDR  (DEV_ADDR)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise),
      .nxt_i     (nxt),
      .wr_stb_o  (wr_stb_o),
      .wr_idx_o  (wr_idx_o),
      .wr_data_o (wr_data_o)
   );
endmodule

// File: tb/tb_serial_reg_rx.sv
`timescale 1ns/1ps
module tb_serial_reg_rx;
   localparam logic [7:0] MY_DEV = 8'hB4;
   localparam int NV = 12;
   // {dev[22:15], idx[14:9], data[8:1], expect_write[0]}
   localparam logic [22:0] VEC [NV] = '{
      {8'hB4, 6'd0,  8'hA5, 1'b1},
      {8'hB4, 6'd7,  8'h01, 1'b1},
      {8'hB4, 6'd31, 8'h3C, 1'b1},
      {8'hB4, 6'd32, 8'hFF, 1'b0},
      {8'hB4, 6'd63, 8'h77, 1'b0},
      {8'h2D, 6'd5,  8'h11, 1'b0},
      {8'hB4, 6'd8,  8'h80, 1'b1},
      {8'hB4, 6'd16, 8'h01, 1'b1},
      {8'hB4, 6'd24, 8'hFE, 1'b1},
      {8'hB5, 6'd3,  8'h22, 1'b0},
      {8'hB4, 6'd42, 8'h55, 1'b0},
      {8'hB4, 6'd1,  8'h6E, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic       wr_stb;
   logic [5:0] wr_idx;
   logic [7:0] wr_data;

   int total = 0;
   int bad = 0;
   int stb_cnt = 0;
   int long_stb = 0;
   logic prev_stb = 1'b0;
   logic [5:0] last_idx = '0;
   logic [7:0] last_data = '0;
   bit   done = 1'b0;
   bit   wiggle = 1'b0;

   always #2.5 clk = ~clk;

   serial_reg_rx #(
      .ADDR_W(8), .IDX_W(6), .DATA_W(8), .REG_COUNT(32),
      .SYNC_STAGES(2), .DEV_ADDR(MY_DEV)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
   );

   always @(posedge clk) begin
      prev_stb <= wr_stb;
      if (wr_stb) begin
         stb_cnt   <= stb_cnt + 1;
         last_idx  <= wr_idx;
         last_data <= wr_data;
         if (prev_stb) long_stb <= long_stb + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic send_bit(input logic b);
      ser_dat = b;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      if (wiggle) begin
         ser_dat = ~b;
         wait_clk(2);
         ser_dat = b;
      end
      wait_clk(2);
      ser_clk = 1'b0;
      wait_clk(4);
   endtask

   task automatic send_field(input logic [7:0] v, input int n);
      for (int i = 0; i < n; i++) send_bit(v[i]);
   endtask

   task automatic send_frame(input logic [7:0] dv, input logic [5:0] ix, input logic [7:0] dt);
      send_field(dv, 8);
      send_field({2'b00, ix}, 6);
      send_field(dt, 8);
      wait_clk(8);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int c0;
      logic [5:0] e_idx;
      logic [7:0] e_data;
      e_idx = '0;
      e_data = '0;
      wait_clk(3);
      // R1 reset state
      check(wr_stb == 1'b0, "R1 strobe in reset", wr_stb, 0);
      check(wr_idx == 6'd0 && wr_data == 8'd0, "R1 outputs in reset", {wr_idx, wr_data}, 0);
      rst_n = 1'b1;
      wait_clk(3);
      check(wr_stb == 1'b0 && stb_cnt == 0, "R1 idle after reset", stb_cnt, 0);

      // table walk: R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         c0 = stb_cnt;
         send_frame(VEC[v][22:15], VEC[v][14:9], VEC[v][8:1]);
         if (VEC[v][0]) begin
            e_idx  = VEC[v][14:9];
            e_data = VEC[v][8:1];
            check(stb_cnt == c0 + 1, "R6 write strobe count", stb_cnt - c0, 1);
         end else begin
            check(stb_cnt == c0, "R5/R7 no write", stb_cnt - c0, 0);
         end
         check(last_idx == e_idx, "R4 index", last_idx, e_idx);
         check(last_data == e_data, "R3 data byte", last_data, e_data);
         check(wr_idx == e_idx && wr_data == e_data, "R8 outputs held", {wr_idx, wr_data}, {e_idx, e_data});
      end
      check(long_stb == 0, "R6 strobe width one cycle", long_stb, 0);

      // R2: data toggles while serial clock is high
      wiggle = 1'b1;
      c0 = stb_cnt;
      send_frame(MY_DEV, 6'd19, 8'h96);
      wiggle = 1'b0;
      check(stb_cnt == c0 + 1 && last_idx == 6'd19 && last_data == 8'h96,
            "R2 only rising edge samples", {last_idx, last_data}, {6'd19, 8'h96});

      // R9: reset in the middle of a frame
      send_field(MY_DEV, 8);
      send_field(8'h05, 3);
      rst_n = 1'b0;
      wait_clk(3);
      check(wr_idx == 6'd0 && wr_data == 8'd0, "R9 reset clears outputs", {wr_idx, wr_data}, 0);
      rst_n = 1'b1;
      wait_clk(3);
      c0 = stb_cnt;
      send_frame(MY_DEV, 6'd23, 8'h4B);
      check(stb_cnt == c0 + 1 && last_idx == 6'd23 && last_data == 8'h4B,
            "R9 frame after mid-frame reset", {last_idx, last_data}, {6'd23, 8'h4B});
      check(long_stb == 0, "R6 strobe width final", long_stb, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule